// File: doc/BRIEF.md
# Double-Buffered Compare Value Pair

This block holds two 16-bit compare values, channel A and channel B, for a PWM time base. Each channel keeps a staging (shadow) copy and a live (active) copy. Software reaches both channels and a shared control word through a small register bus with a single-cycle write strobe and a combinational read port. The active value is compared against an external time-base counter, and each channel raises an equality output while the two match.

Each channel can work in one of two ways. In staged mode a write lands in the shadow copy and sets a pending flag. The shadow copy then moves into the active copy on a time-base event chosen by that channel's load selector: counter at zero, counter at period, either of the two, or never. In immediate mode a write goes straight into the active copy. A mirror address for each channel always reads back the live value. The plain value address reads back whatever the next write would replace.

Top module: `cmp_shadow_pair`

## Requirements
- R1: After reset both shadow copies, both active copies, both pending flags and the control word are 0. In the reset state both channels are staged and load at counter zero.
- R2: In staged mode (the channel's immediate bit is 0), a write to that channel stores the data in the shadow copy only. The active copy is unchanged after the write edge.
- R3: In immediate mode (immediate bit 1), a write stores the data in the active copy on the write edge and leaves the shadow copy unchanged. It also clears that channel's pending flag, so the write does not set it.
- R4: Address 2 (channel A) and address 3 (channel B) always read the active copy, whatever the mode. A write to either of these mirror addresses acts exactly like a write to address 0 or 1 of the same channel.
- R5: The 2-bit load selector sets the event that copies the shadow into the active copy: 00 loads on the counter-at-zero strobe, 01 on the counter-at-period strobe, 10 on either strobe, and 11 never loads.
- R6: The pending flag is set by a staged write and cleared by the edge that copies shadow into active. It reads back at control-word bit 8 for channel A and bit 9 for channel B, and also appears on ports full_a and full_b.
- R7: The channels are independent. Control word bit 0 is A's immediate bit and bits 2:1 are A's selector; bit 3 is B's immediate bit and bits 5:4 are B's selector. An event that loads one channel leaves the other alone.
- R8: A copy takes place only while the pending flag is set. A load event with no pending value leaves the active copy unchanged, even when the shadow differs.
- R9: Address 0 (A) and address 1 (B) read the shadow copy in staged mode and the active copy in immediate mode. Address 4 reads the control word.
- R10: eq_a and eq_b are high in exactly the cycles where tb_count equals that channel's active copy.
- R11: When a staged write and a copy happen on the same edge, the old shadow value moves to active, the new data goes into the shadow, and the pending flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Register address (0..4) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| tb_count | input | 16 | External time-base counter value |
| tb_at_zero | input | 1 | Strobe: counter is at zero this cycle |
| tb_at_period | input | 1 | Strobe: counter is at period this cycle |
| eq_a | output | 1 | Counter equals channel A active value |
| eq_b | output | 1 | Counter equals channel B active value |
| full_a | output | 1 | Channel A shadow value pending |
| full_b | output | 1 | Channel B shadow value pending |

## Verification
The bench goes after the events that do not match the selector. A design that decodes the selector wrongly would load on the period strobe while set to zero-only, or would load at all while frozen. It also fires load events with no pending value after an immediate write. A design that copies regardless of the flag would overwrite the immediate value with stale shadow data. A staged write and a zero strobe land on the same edge: a design that clears the flag last would lose the queued value, which the next event then shows. Mirror and plain addresses are read back in both modes to catch a read mux that returns the wrong copy.

// File: rtl/cmp_pair_pkg.sv
`timescale 1ns/1ps
package cmp_pair_pkg;

  typedef enum logic [1:0] {
    LD_ZERO   = 2'b00,
    LD_PERIOD = 2'b01,
    LD_EITHER = 2'b10,
    LD_FREEZE = 2'b11
  } load_sel_e;

  // Per-channel control slice: {sel[1:0], immediate}
  typedef struct packed {
    load_sel_e sel;
    logic      immediate;
  } chan_cfg_t;

  localparam int unsigned CFG_W    = $bits(chan_cfg_t);
  localparam int unsigned STAT_LSB = 8;

  // Does the selected time-base event occur this cycle?
  function automatic logic load_event(load_sel_e sel, logic at_zero, logic at_period);
    case (sel)
      LD_ZERO:   return at_zero;
      LD_PERIOD: return at_period;
      LD_EITHER: return at_zero | at_period;
      default:   return 1'b0;
    endcase
  endfunction

  // Next pending-flag state: a staged write wins over a copy.
  function automatic logic next_pending(logic cur, logic staged_wr, logic imm_wr, logic copy);
    if (staged_wr)   return 1'b1;
    else if (imm_wr) return 1'b0;
    else if (copy)   return 1'b0;
    else             return cur;
  endfunction

endpackage

// File: rtl/cmp_chan.sv
`timescale 1ns/1ps
module cmp_chan
  import cmp_pair_pkg::*;
#(
  parameter int unsigned VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  chan_cfg_t        cfg,
  input  logic             wr_en,
  input  logic [VAL_W-1:0] wr_data,
  input  logic             at_zero,
  input  logic             at_period,
  input  logic [VAL_W-1:0] count,
  output logic [VAL_W-1:0] shadow_q,
  output logic [VAL_W-1:0] active_q,
  output logic             pending_q,
  output logic             match,
  output logic             staged_wr,
  output logic             imm_wr,
  output logic             copy
);

  logic evt;

  assign staged_wr = wr_en & ~cfg.immediate;
  assign imm_wr    = wr_en &  cfg.immediate;
  assign evt       = load_event(cfg.sel, at_zero, at_period);
  assign copy      = evt & pending_q & ~imm_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q  <= '0;
      active_q  <= '0;
      pending_q <= 1'b0;
    end else begin
      if (staged_wr) shadow_q <= wr_data;
      if (imm_wr)    active_q <= wr_data;
      else if (copy) active_q <= shadow_q;
      pending_q <= next_pending(pending_q, staged_wr, imm_wr, copy);
    end
  end

  assign match = (count == active_q);

endmodule

// File: rtl/cmp_regs.sv
`timescale 1ns/1ps
module cmp_regs
  import cmp_pair_pkg::*;
#(
  parameter int unsigned VAL_W  = 16,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned NCH    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [VAL_W-1:0]           bus_wdata,
  input  logic [NCH-1:0][VAL_W-1:0]  shadow,
  input  logic [NCH-1:0][VAL_W-1:0]  active,
  input  logic [NCH-1:0]             pending,
  output chan_cfg_t [NCH-1:0]        cfg,
  output logic [NCH-1:0]             ch_wr,
  output logic [VAL_W-1:0]           bus_rdata
);

  localparam int unsigned CTRL_W    = CFG_W * NCH;
  localparam int unsigned CTRL_ADDR = 2 * NCH;

  logic [CTRL_W-1:0] ctrl_q;
  logic              ctrl_sel;

  assign ctrl_sel = (bus_addr == ADDR_W'(CTRL_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ctrl_q <= '0;
    else if (bus_wr && ctrl_sel) ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_dec
    assign cfg[ch]   = chan_cfg_t'(ctrl_q[ch*CFG_W +: CFG_W]);
    assign ch_wr[ch] = bus_wr & ((bus_addr == ADDR_W'(ch)) |
                                 (bus_addr == ADDR_W'(NCH + ch)));
  end

  always_comb begin
    bus_rdata = '0;
    for (int ch = 0; ch < NCH; ch++) begin
      if (bus_addr == ADDR_W'(ch))
        bus_rdata = cfg[ch].immediate ? active[ch] : shadow[ch];
      if (bus_addr == ADDR_W'(NCH + ch))
        bus_rdata = active[ch];
    end
    if (ctrl_sel) begin
      bus_rdata[CTRL_W-1:0] = ctrl_q;
      for (int ch = 0; ch < NCH; ch++)
        bus_rdata[STAT_LSB + ch] = pending[ch];
    end
  end

endmodule

// File: rtl/cmp_shadow_pair.sv
`timescale 1ns/1ps
module cmp_shadow_pair
  import cmp_pair_pkg::*;
#(
  parameter int unsigned VAL_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [VAL_W-1:0]  bus_wdata,
  output logic [VAL_W-1:0]  bus_rdata,
  input  logic [VAL_W-1:0]  tb_count,
  input  logic              tb_at_zero,
  input  logic              tb_at_period,
  output logic              eq_a,
  output logic              eq_b,
  output logic              full_a,
  output logic              full_b
);

  localparam int unsigned NCH = 2;

  chan_cfg_t [NCH-1:0]       cfg;
  logic [NCH-1:0]            ch_wr;
  logic [NCH-1:0][VAL_W-1:0] shadow;
  logic [NCH-1:0][VAL_W-1:0] active;
  logic [NCH-1:0]            pending;
  logic [NCH-1:0]            match;
  logic [NCH-1:0]            staged_wr;
  logic [NCH-1:0]            imm_wr;
  logic [NCH-1:0]            copy;
  logic [NCH-1:0]            frozen;

  cmp_regs #(.VAL_W(VAL_W), .ADDR_W(ADDR_W), .NCH(NCH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .shadow    (shadow),
    .active    (active),
    .pending   (pending),
    .cfg       (cfg),
    .ch_wr     (ch_wr),
    .bus_rdata (bus_rdata)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    cmp_chan #(.VAL_W(VAL_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg       (cfg[ch]),
      .wr_en     (ch_wr[ch]),
      .wr_data   (bus_wdata),
      .at_zero   (tb_at_zero),
      .at_period (tb_at_period),
      .count     (tb_count),
      .shadow_q  (shadow[ch]),
      .active_q  (active[ch]),
      .pending_q (pending[ch]),
      .match     (match[ch]),
      .staged_wr (staged_wr[ch]),
      .imm_wr    (imm_wr[ch]),
      .copy      (copy[ch])
    );
    assign frozen[ch] = (cfg[ch].sel == LD_FREEZE);
  end

  assign eq_a   = match[0];
  assign eq_b   = match[1];
  assign full_a = pending[0];
  assign full_b = pending[1];

endmodule

// File: rtl/cmp_shadow_pair_chk.sv
`timescale 1ns/1ps
module cmp_shadow_pair_chk #(
  parameter int unsigned VAL_W  = 16,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned NCH    = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [VAL_W-1:0]          bus_wdata,
  input logic [VAL_W-1:0]          bus_rdata,
  input logic [NCH-1:0][VAL_W-1:0] active,
  input logic [NCH-1:0]            pending,
  input logic [NCH-1:0]            staged_wr,
  input logic [NCH-1:0]            imm_wr,
  input logic [NCH-1:0]            copy,
  input logic [NCH-1:0]            frozen
);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
    AST_STAGED_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      staged_wr[ch] && !copy[ch] |=> $stable(active[ch])); // R2
    AST_IMMEDIATE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      imm_wr[ch] |=> (active[ch] == $past(bus_wdata)) && !pending[ch]); // R3
    AST_MIRROR_IS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr == ADDR_W'(NCH + ch) |-> bus_rdata == active[ch]); // R4
    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      frozen[ch] && !imm_wr[ch] |=> $stable(active[ch])); // R5
    AST_PENDING_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      staged_wr[ch] |=> pending[ch]); // R6
    AST_COPY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      copy[ch] && !staged_wr[ch] |=> !pending[ch]); // R6
    AST_NO_STALE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      !pending[ch] && !imm_wr[ch] |=> $stable(active[ch])); // R8
  end

endmodule

bind cmp_shadow_pair cmp_shadow_pair_chk #(.VAL_W(VAL_W), .ADDR_W(ADDR_W), .NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .active    (active),
  .pending   (pending),
  .staged_wr (staged_wr),
  .imm_wr    (imm_wr),
  .copy      (copy),
  .frozen    (frozen)
);

// File: tb/test_cmp_shadow_pair.sv
`timescale 1ns/1ps
module test_cmp_shadow_pair;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_EV = 2'd2, OP_CNT = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  addr;
    logic [15:0] data;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 49;
  localparam vec_t VECS [NV] = '{
    '{OP_RD, 3'd2, 16'h0000, 16'h0000, 4'd1},   // R1 A mirror
    '{OP_RD, 3'd4, 16'h0000, 16'h0000, 4'd1},   // R1 control word
    '{OP_RD, 3'd1, 16'h0000, 16'h0000, 4'd1},   // R1 B shadow
    '{OP_WR, 3'd0, 16'h1234, 16'h0000, 4'd2},
    '{OP_RD, 3'd0, 16'h0000, 16'h1234, 4'd9},   // R9 staged read = shadow
    '{OP_RD, 3'd2, 16'h0000, 16'h0000, 4'd2},   // R2 active untouched
    '{OP_RD, 3'd4, 16'h0000, 16'h0100, 4'd6},   // R6 A pending
    '{OP_EV, 3'd0, 16'h0002, 16'h0000, 4'd5},   // period only
    '{OP_RD, 3'd2, 16'h0000, 16'h0000, 4'd5},   // R5 zero-mode ignores period
    '{OP_EV, 3'd0, 16'h0001, 16'h0000, 4'd5},
    '{OP_RD, 3'd2, 16'h0000, 16'h1234, 4'd5},   // R5 loaded on zero
    '{OP_RD, 3'd4, 16'h0000, 16'h0000, 4'd6},   // R6 cleared
    '{OP_WR, 3'd4, 16'h0001, 16'h0000, 4'd3},
    '{OP_WR, 3'd0, 16'h0AAA, 16'h0000, 4'd3},
    '{OP_RD, 3'd2, 16'h0000, 16'h0AAA, 4'd3},   // R3 immediate
    '{OP_RD, 3'd0, 16'h0000, 16'h0AAA, 4'd9},   // R9 immediate read = active
    '{OP_RD, 3'd4, 16'h0000, 16'h0001, 4'd3},   // R3 no pending
    '{OP_WR, 3'd4, 16'h0000, 16'h0000, 4'd8},
    '{OP_RD, 3'd0, 16'h0000, 16'h1234, 4'd9},   // R9 shadow kept
    '{OP_EV, 3'd0, 16'h0001, 16'h0000, 4'd8},
    '{OP_RD, 3'd2, 16'h0000, 16'h0AAA, 4'd8},   // R8 no stale copy
    '{OP_WR, 3'd4, 16'h0010, 16'h0000, 4'd7},
    '{OP_WR, 3'd1, 16'h00C8, 16'h0000, 4'd7},
    '{OP_EV, 3'd0, 16'h0001, 16'h0000, 4'd7},
    '{OP_RD, 3'd3, 16'h0000, 16'h0000, 4'd5},   // R5 period-mode ignores zero
    '{OP_RD, 3'd4, 16'h0000, 16'h0210, 4'd6},   // R6 B pending bit 9
    '{OP_EV, 3'd0, 16'h0002, 16'h0000, 4'd7},
    '{OP_RD, 3'd3, 16'h0000, 16'h00C8, 4'd5},   // R5 loaded on period
    '{OP_RD, 3'd2, 16'h0000, 16'h0AAA, 4'd7},   // R7 A unaffected
    '{OP_WR, 3'd3, 16'h00D0, 16'h0000, 4'd4},
    '{OP_RD, 3'd3, 16'h0000, 16'h00C8, 4'd4},   // R4 mirror still active
    '{OP_RD, 3'd1, 16'h0000, 16'h00D0, 4'd4},   // R4 mirror write staged
    '{OP_WR, 3'd4, 16'h0024, 16'h0000, 4'd5},
    '{OP_WR, 3'd0, 16'h0300, 16'h0000, 4'd5},
    '{OP_EV, 3'd0, 16'h0002, 16'h0000, 4'd5},
    '{OP_RD, 3'd2, 16'h0000, 16'h0300, 4'd5},   // R5 either mode
    '{OP_RD, 3'd3, 16'h0000, 16'h00D0, 4'd5},   // R5 either mode
    '{OP_WR, 3'd4, 16'h0036, 16'h0000, 4'd5},
    '{OP_WR, 3'd1, 16'h0099, 16'h0000, 4'd5},
    '{OP_EV, 3'd0, 16'h0003, 16'h0000, 4'd5},
    '{OP_RD, 3'd3, 16'h0000, 16'h00D0, 4'd5},   // R5 freeze
    '{OP_RD, 3'd4, 16'h0000, 16'h0236, 4'd6},   // R6 still pending
    '{OP_CNT, 3'd0, 16'h00D0, 16'h0002, 4'd10}, // R10 B match
    '{OP_CNT, 3'd0, 16'h0300, 16'h0001, 4'd10}, // R10 A match
    '{OP_CNT, 3'd0, 16'h0001, 16'h0000, 4'd10}, // R10 none
    '{OP_WR, 3'd4, 16'h0031, 16'h0000, 4'd10},
    '{OP_WR, 3'd0, 16'h00D0, 16'h0000, 4'd10},
    '{OP_CNT, 3'd0, 16'h00D0, 16'h0003, 4'd10}, // R10 both
    '{OP_CNT, 3'd0, 16'h0000, 16'h0000, 4'd10}  // R10 none
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] tb_count = '0;
  logic        tb_at_zero = 1'b0;
  logic        tb_at_period = 1'b0;
  logic        eq_a, eq_b, full_a, full_b;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmp_shadow_pair i_cmp_shadow_pair (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tb_count(tb_count),
    .tb_at_zero(tb_at_zero), .tb_at_period(tb_at_period),
    .eq_a(eq_a), .eq_b(eq_b), .full_a(full_a), .full_b(full_b)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic strobe(input logic [1:0] ev);
    @(negedge clk);
    tb_at_zero = ev[0]; tb_at_period = ev[1];
    @(negedge clk);
    tb_at_zero = 1'b0; tb_at_period = 1'b0;
  endtask

  task automatic read_check(input logic [2:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    bus_addr = a;
    #1 check(req, bus_rdata, exp);
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check("R1 full flags", {14'd0, full_b, full_a}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec %0d", VECS[i].req, i);
      case (VECS[i].op)
        OP_WR: bus_write(VECS[i].addr, VECS[i].data);
        OP_EV: strobe(VECS[i].data[1:0]);
        OP_RD: read_check(VECS[i].addr, VECS[i].exp, tag);
        default: begin
          @(negedge clk);
          tb_count = VECS[i].data;
          #1 check(tag, {14'd0, eq_b, eq_a}, VECS[i].exp);
        end
      endcase
    end

    // R11: staged write coinciding with a zero-strobe copy
    bus_write(3'd4, 16'h0030);
    bus_write(3'd0, 16'h0111);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 16'h0222; tb_at_zero = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tb_at_zero = 1'b0;
    read_check(3'd2, 16'h0111, "R11 old shadow moved");
    read_check(3'd0, 16'h0222, "R11 new shadow kept");
    read_check(3'd4, 16'h0330, "R11 pending stays set");
    check("R11 full_a port", {15'd0, full_a}, 16'h0001);
    strobe(2'b01);
    read_check(3'd2, 16'h0222, "R11 queued value loads");

    // R1: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    read_check(3'd2, 16'h0000, "R1 A active after reset");
    read_check(3'd3, 16'h0000, "R1 B active after reset");
    read_check(3'd1, 16'h0000, "R1 B shadow after reset");
    read_check(3'd4, 16'h0000, "R1 control after reset");
    rst_n = 1'b1;
    finish_run();
  end

endmodule